// File: doc/BRIEF.md
# Multi-Mode Programmable Feedback Divider

This block is the programmable feedback divider of a frequency-synthesizer loop. It takes edge strobes from two oscillator inputs, a high-band one and a low-band one, picks one of them according to a runtime mode, and divides it by a programmed ratio N. Every completed division produces one single-cycle pulse on `div_out`, which feeds the phase comparator. Each input edge arrives as a one-cycle strobe (`hb_tick`, `lb_tick`) synchronous to `clk`.

Four modes are available. The high band can be halved first and then pulse-swallowed, or pulse-swallowed directly. The low band can be pulse-swallowed or divided directly. Pulse swallowing uses a built-in dual-modulus prescaler of modulus P/P+1 (P = 2^PSC_LOG2, 8 by default), a main count M and a swallow count A, with N = P*M + A. `mod_ctl` shows the prescaler modulus request. When the low-band direct mode is combined with `ext_psc`, the built-in prescaler is bypassed. The low-band strobes are then taken as the outputs of an outside prescaler, which `mod_ctl` steers. Mode and ratio changes take effect only at the end of a division. With `pll_en` low the block is quiet and ignores both inputs.

Top module: `pll_fb_divider`

## Requirements
- R1: After reset, and for as long as `pll_en` is low, `div_out` and `mod_ctl` stay 0 whatever strobes arrive.
- R2: Mode 2'b11 with `ext_psc` low divides the low-band strobes by N: one `div_out` pulse per N strobes, asserted in the cycle after the strobe that completes the count.
- R3: Mode 2'b01 divides the high-band strobes by N = 8*M + A, with A = N[2:0] and M = N[15:3]. The first A prescaler cycles of each division use modulus 9 and the rest use modulus 8.
- R4: Mode 2'b00 halves the high-band strobes before pulse swallowing, giving one pulse per 2*N high-band strobes.
- R5: Mode 2'b10 pulse-swallows the low-band strobes, giving one pulse per N strobes.
- R6: Strobes on the input that the current mode does not select have no effect on the division.
- R7: Mode 2'b11 with `ext_psc` high gives one pulse per M = N[15:3] low-band strobes. `mod_ctl` is high at the start of each division and falls in the cycle after the A-th strobe, with A = N[2:0].
- R8: Changes to `ratio_n`, `div_mode` and `ext_psc` made during a division leave that division unchanged. The next division uses the new values.
- R9: Every `div_out` pulse lasts exactly one clock cycle.
- R10: Mode encoding: 2'b00 selects high band halved then swallowed, 2'b01 high band swallowed, 2'b10 low band swallowed, 2'b11 low band direct.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pll_en | input | 1 | Divider enable; low holds the block quiet |
| div_mode | input | 2 | Division mode (see R10) |
| ext_psc | input | 1 | Outside-prescaler control in low-band direct mode |
| ratio_n | input | NW (16) | Division ratio N |
| hb_tick | input | 1 | High-band input edge strobe |
| lb_tick | input | 1 | Low-band input edge strobe |
| div_out | output | 1 | One-cycle pulse per completed division |
| mod_ctl | output | 1 | Prescaler modulus request, high for P+1 |

## Verification
The assertions assume legal ratios. N is at least 2 in direct division. In pulse-swallow modes M is at least 1 and no smaller than A. With an outside prescaler M is at least 2. The strobes are also assumed to be one-cycle pulses in the `clk` domain. The stimulus keeps to these limits: it programs only ratios such as 2, 5, 8, 9, 13, 26, 45, 51 and 79. It changes configuration mid-division only in the dedicated R8 case. It drives strobes at random densities, with noise on the unselected input, so the counts and the modulus switching are exercised under irregular spacing.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;

    typedef enum logic [1:0] {
        MODE_HB_HALF_SWL = 2'b00,
        MODE_HB_SWL      = 2'b01,
        MODE_LB_SWL      = 2'b10,
        MODE_LB_DIRECT   = 2'b11
    } div_mode_e;

    typedef struct packed {
        div_mode_e mode;
        logic      ext_psc;
    } mode_cfg_t;

    function automatic logic takes_high_band(mode_cfg_t c);
        return (c.mode == MODE_HB_HALF_SWL) || (c.mode == MODE_HB_SWL);
    endfunction

    function automatic logic halves_input(mode_cfg_t c);
        return c.mode == MODE_HB_HALF_SWL;
    endfunction

    function automatic logic uses_internal_psc(mode_cfg_t c);
        return c.mode != MODE_LB_DIRECT;
    endfunction

    function automatic logic uses_swallow(mode_cfg_t c);
        return uses_internal_psc(c) || c.ext_psc;
    endfunction

endpackage

// File: rtl/pdiv_input_sel.sv
module pdiv_input_sel
    import pdiv_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    input  mode_cfg_t cfg,
    input  logic      hb_tick,
    input  logic      lb_tick,
    output logic      sel_tick
);

    logic half_q;
    logic raw_tick;

    always_comb begin
        raw_tick = run & (takes_high_band(cfg) ? hb_tick : lb_tick);
        sel_tick = raw_tick & (halves_input(cfg) ? half_q : 1'b1);
    end

    // Divide-by-two phase; returns to 0 after every passed strobe.
    always_ff @(posedge clk) begin
        if (rst || !run || !halves_input(cfg))
            half_q <= 1'b0;
        else if (raw_tick)
            half_q <= ~half_q;
    end

    // R4: in halving mode no two consecutive selected strobes both pass.
    assert_half_alternates_R4: assert property (@(posedge clk) disable iff (rst)
        (run && halves_input(cfg) && sel_tick) |=> !(sel_tick && halves_input(cfg)));

endmodule

// File: rtl/pdiv_prescaler.sv
module pdiv_prescaler #(
    parameter int PSC_LOG2 = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic bypass,
    input  logic in_tick,
    input  logic mod_hi,
    output logic pre_tick
);

    localparam int PSC_MOD = 1 << PSC_LOG2;
    localparam int CW      = PSC_LOG2 + 1;

    logic [CW-1:0] pc_q;
    logic [CW-1:0] last;
    logic          wrap;

    always_comb begin
        last     = mod_hi ? CW'(PSC_MOD) : CW'(PSC_MOD - 1);
        wrap     = in_tick & (pc_q == last);
        pre_tick = bypass ? in_tick : wrap;
    end

    always_ff @(posedge clk) begin
        if (rst || !run || bypass)
            pc_q <= '0;
        else if (in_tick)
            pc_q <= wrap ? '0 : pc_q + CW'(1);
    end

    // R3: prescaler phase never exceeds the larger modulus.
    assert_psc_in_range_R3: assert property (@(posedge clk) disable iff (rst)
        (run && !bypass) |-> (pc_q <= CW'(PSC_MOD)));

endmodule

// File: rtl/pdiv_ratio_ctr.sv
module pdiv_ratio_ctr #(
    parameter int NW       = 16,
    parameter int PSC_LOG2 = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic                swallow,
    input  logic [NW-1:0]       ratio_q,
    input  logic [PSC_LOG2-1:0] swl_nx,
    input  logic                pre_tick,
    output logic                done,
    output logic                mod_hi
);

    logic [NW-1:0]       cnt_q;
    logic [NW-1:0]       last;
    logic [PSC_LOG2-1:0] acnt_q;

    always_comb begin
        if (swallow)
            last = (ratio_q >> PSC_LOG2) - NW'(1);
        else
            last = ratio_q - NW'(1);
        done   = pre_tick & (cnt_q == last);
        mod_hi = run & swallow & (acnt_q != '0);
    end

    always_ff @(posedge clk) begin
        if (rst || !run || done) begin
            cnt_q  <= '0;
            acnt_q <= swl_nx;
        end else if (pre_tick) begin
            cnt_q <= cnt_q + NW'(1);
            if (acnt_q != '0)
                acnt_q <= acnt_q - PSC_LOG2'(1);
        end
    end

    // R2: the division count stays within the programmed limit.
    assert_count_in_range_R2: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q <= last));

endmodule

// File: rtl/pll_fb_divider.sv
module pll_fb_divider
    import pdiv_pkg::*;
#(
    parameter int NW       = 16,
    parameter int PSC_LOG2 = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pll_en,
    input  logic [1:0]    div_mode,
    input  logic          ext_psc,
    input  logic [NW-1:0] ratio_n,
    input  logic          hb_tick,
    input  logic          lb_tick,
    output logic          div_out,
    output logic          mod_ctl
);

    mode_cfg_t     cfg_in;
    mode_cfg_t     cfg_q;
    logic [NW-1:0] ratio_q;
    logic          sel_tick;
    logic          pre_tick;
    logic          done;
    logic          mod_hi;
    logic          div_q;

    always_comb begin
        cfg_in.mode    = div_mode_e'(div_mode);
        cfg_in.ext_psc = ext_psc;
    end

    // Active configuration: follows the ports only while idle or at a division end.
    always_ff @(posedge clk) begin
        if (rst || !pll_en || done) begin
            cfg_q   <= cfg_in;
            ratio_q <= ratio_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            div_q <= 1'b0;
        else
            div_q <= done;
    end

    pdiv_input_sel u_sel (
        .clk      (clk),
        .rst      (rst),
        .run      (pll_en),
        .cfg      (cfg_q),
        .hb_tick  (hb_tick),
        .lb_tick  (lb_tick),
        .sel_tick (sel_tick)
    );

    pdiv_prescaler #(.PSC_LOG2(PSC_LOG2)) u_psc (
        .clk      (clk),
        .rst      (rst),
        .run      (pll_en),
        .bypass   (!uses_internal_psc(cfg_q)),
        .in_tick  (sel_tick),
        .mod_hi   (mod_hi),
        .pre_tick (pre_tick)
    );

    pdiv_ratio_ctr #(.NW(NW), .PSC_LOG2(PSC_LOG2)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .run      (pll_en),
        .swallow  (uses_swallow(cfg_q)),
        .ratio_q  (ratio_q),
        .swl_nx   (ratio_n[PSC_LOG2-1:0]),
        .pre_tick (pre_tick),
        .done     (done),
        .mod_hi   (mod_hi)
    );

    assign div_out = div_q;
    assign mod_ctl = mod_hi;

    assert_quiet_when_off_R1: assert property (@(posedge clk) disable iff (rst)
        !pll_en |=> !div_out);

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        div_out |=> !div_out);

    assert_cfg_held_R8: assert property (@(posedge clk) disable iff (rst)
        (pll_en && $past(pll_en) && !$past(done) && !$past(rst))
            |-> ($stable(ratio_q) && $stable(cfg_q)));

    assert_mod_falls_on_prescale_R7: assert property (@(posedge clk) disable iff (rst)
        (pll_en && !$past(rst) && $fell(mod_ctl)) |-> $past(pre_tick));

endmodule

// File: tb/pll_fb_divider_test.sv
module pll_fb_divider_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pll_en = 1'b0;
    logic [1:0]  div_mode = 2'b11;
    logic        ext_psc = 1'b0;
    logic [15:0] ratio_n = 16'd2;
    logic        hb_tick = 1'b0;
    logic        lb_tick = 1'b0;
    logic        div_out;
    logic        mod_ctl;

    int total = 0;
    int bad = 0;
    int exp_q[$];
    bit mon_on = 1'b0;
    bit sel_hb = 1'b0;
    bit ext_chk = 1'b0;
    int swl_a = 0;
    int tick_cnt = 0;
    bit prev_out = 1'b0;
    string tag = "R2";

    always #4 clk = ~clk;

    pll_fb_divider uut (
        .clk(clk), .rst(rst), .pll_en(pll_en), .div_mode(div_mode),
        .ext_psc(ext_psc), .ratio_n(ratio_n), .hb_tick(hb_tick),
        .lb_tick(lb_tick), .div_out(div_out), .mod_ctl(mod_ctl)
    );

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (mon_on) begin
            if (div_out) begin
                total++;
                if (prev_out) begin
                    bad++;
                    $display("FAIL R9: pulse width actual=2+ expected=1");
                end
                total++;
                if (exp_q.size() == 0) begin
                    bad++;
                    $display("FAIL %s: unexpected pulse actual=%0d expected=none", tag, tick_cnt);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    if (tick_cnt != e) begin
                        bad++;
                        $display("FAIL %s: strobes per pulse actual=%0d expected=%0d", tag, tick_cnt, e);
                    end
                end
                tick_cnt = 0;
            end
            if (ext_chk) begin
                total++;
                if (mod_ctl !== (tick_cnt < swl_a)) begin
                    bad++;
                    $display("FAIL R7: mod_ctl actual=%0b expected=%0b", mod_ctl, tick_cnt < swl_a);
                end
            end
            if (pll_en && (sel_hb ? hb_tick : lb_tick))
                tick_cnt++;
            prev_out = div_out;
        end
    end

    task automatic step(input int dens, input bit noise);
        @(posedge clk);
        #1;
        if (sel_hb) begin
            hb_tick = ($urandom_range(0, 99) < dens);
            lb_tick = noise ? ($urandom_range(0, 1) == 1) : 1'b0;
        end else begin
            lb_tick = ($urandom_range(0, 99) < dens);
            hb_tick = noise ? ($urandom_range(0, 1) == 1) : 1'b0;
        end
    endtask

    task automatic idle_cfg(input logic [1:0] m, input logic [15:0] n, input logic x);
        @(posedge clk);
        #1;
        pll_en = 1'b0;
        hb_tick = 1'b0;
        lb_tick = 1'b0;
        mon_on = 1'b0;
        ext_chk = 1'b0;
        div_mode = m;
        ratio_n = n;
        ext_psc = x;
        repeat (2) @(posedge clk);
    endtask

    task automatic run(input logic [1:0] m, input int n, input bit x,
                       input int pulses, input int dens, input bit noise, input string t);
        int e;
        idle_cfg(m, 16'(n), x);
        sel_hb = (m == 2'b00) || (m == 2'b01);
        if (m == 2'b00) e = 2 * n;
        else if (m == 2'b11 && x) e = n / 8;
        else e = n;
        for (int i = 0; i < pulses; i++) exp_q.push_back(e);
        tag = t;
        swl_a = n % 8;
        tick_cnt = 0;
        prev_out = 1'b0;
        ext_chk = (m == 2'b11) && x;
        #1;
        mon_on = 1'b1;
        pll_en = 1'b1;
        while (exp_q.size() > 0) step(dens, noise);
        idle_cfg(m, 16'(n), x);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run hung actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seen;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        total++;
        if (div_out !== 1'b0 || mod_ctl !== 1'b0) begin
            bad++;
            $display("FAIL R1: reset outputs actual=%0b%0b expected=00", div_out, mod_ctl);
        end

        // R1: disabled with dense strobes and an outside-prescaler config with A>0
        div_mode = 2'b11; ext_psc = 1'b1; ratio_n = 16'd51;
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            @(posedge clk);
            #1 hb_tick = 1'b1; lb_tick = 1'b1;
            @(negedge clk);
            if (div_out || mod_ctl) seen++;
        end
        total++;
        if (seen != 0) begin
            bad++;
            $display("FAIL R1: active cycles while off actual=%0d expected=0", seen);
        end

        run(2'b11, 2, 0, 6, 100, 0, "R2");
        run(2'b11, 13, 0, 4, 40, 1, "R6");
        run(2'b01, 26, 0, 4, 100, 0, "R3");
        run(2'b01, 79, 0, 3, 60, 1, "R3");
        run(2'b01, 8, 0, 4, 100, 0, "R10");
        run(2'b00, 26, 0, 3, 70, 0, "R4");
        run(2'b00, 9, 0, 3, 100, 1, "R4");
        run(2'b10, 45, 0, 3, 50, 1, "R5");
        run(2'b10, 45, 1, 2, 100, 0, "R5");
        run(2'b11, 51, 1, 4, 60, 1, "R7");

        // R8: change the ratio during the second division
        idle_cfg(2'b11, 16'd5, 1'b0);
        sel_hb = 1'b0;
        tag = "R8";
        exp_q.push_back(5); exp_q.push_back(5); exp_q.push_back(9); exp_q.push_back(9);
        tick_cnt = 0; prev_out = 1'b0;
        #1 mon_on = 1'b1; pll_en = 1'b1;
        while (exp_q.size() > 3) step(50, 0);
        ratio_n = 16'd9;
        while (exp_q.size() > 0) step(50, 0);
        idle_cfg(2'b11, 16'd9, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule